// File: doc/BRIEF.md
# Crossbar Nibble/Byte Table Lookup

This unit treats one operand as a small table of equal-width elements and the other as a vector of indexes. It replaces every index element with the table element that index names. The element width is chosen per operation: 4-bit nibbles or 8-bit bytes. An index that points past the end of the table produces a zero element. The unit is meant for constant-time S-box substitution and bit or byte permutation layers in cipher code, where the lookup must not reveal secret values through timing.

Operands arrive with a valid strobe. The result appears, registered, exactly one clock later with its own valid. The datapath is fully parallel, and its latency does not depend on the mode, the table or the indexes. The word width `XLEN` is a parameter and may be 32 or 64.

Top module: `xbl_lookup`

## Requirements
- R1: With `in_mode` = 0 (nibble mode), result nibble i (bits [4i+3:4i]) equals table nibble k, where k is index nibble i. Element 0 is the least significant element of every operand.
- R2: With `in_mode` = 1 (byte mode), result byte i (bits [8i+7:8i]) equals table byte k, where k is index byte i.
- R3: In nibble mode, a result nibble is zero when its index is greater than or equal to XLEN/4. With XLEN = 32 this covers index values 8 to 15.
- R4: In byte mode, a result byte is zero when its index is greater than or equal to XLEN/8. With XLEN = 32 this covers index values 4 to 255.
- R5: `out_valid` is high in the cycle after every cycle in which `in_valid` is high. The result for those operands is present in that same cycle. The latency is the same for every mode and every operand value, and back-to-back operations are accepted.
- R6: After a cycle with `in_valid` low, `out_valid` is low and `out_result` keeps its previous value, whatever the other inputs do.
- R7: While `rst` is high, on the following edge `out_valid` and `out_result` become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| in_mode | input | 1 | Element size: 0 nibble, 1 byte |
| in_tbl | input | XLEN | Table operand |
| in_index | input | XLEN | Index operand |
| out_valid | output | 1 | Result valid |
| out_result | output | XLEN | Lookup result |

## Verification
The assertions assume that `in_mode`, `in_tbl` and `in_index` are known whenever `in_valid` is high. They also assume that reset is held for at least one edge before the first operation. The stimulus keeps to both: reset is asserted for several cycles, and every input is driven to a defined value on the falling edge before it is captured. Idle cycles change the table and the indexes on purpose, to show that those inputs are ignored while `in_valid` is low.

// File: rtl/xbl_pkg.sv
package xbl_pkg;

    typedef enum logic {
        XBL_NIBBLE = 1'b0,
        XBL_BYTE   = 1'b1
    } xbl_mode_e;

    localparam int unsigned NIB_W  = 4;
    localparam int unsigned BYTE_W = 8;

    // True when index k lies outside a table of n entries.
    function automatic logic xbl_oob(input logic [7:0] k, input int unsigned n);
        logic [31:0] kw;
        kw = {24'd0, k};
        return kw >= n;
    endfunction

endpackage

// File: rtl/xbl_nib_xbar.sv
module xbl_nib_xbar
    import xbl_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] tbl,
    input  logic [XLEN-1:0] index,
    output logic [XLEN-1:0] result
);
    localparam int unsigned LANES = XLEN / NIB_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [NIB_W-1:0] k;
        logic [XLEN-1:0]  shifted;
        assign k       = index[i*NIB_W +: NIB_W];
        assign shifted = tbl >> {k, 2'b00};
        assign result[i*NIB_W +: NIB_W] =
            xbl_oob({4'd0, k}, LANES) ? '0 : shifted[NIB_W-1:0];
    end

endmodule

// File: rtl/xbl_byte_xbar.sv
module xbl_byte_xbar
    import xbl_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] tbl,
    input  logic [XLEN-1:0] index,
    output logic [XLEN-1:0] result
);
    localparam int unsigned LANES = XLEN / BYTE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] k;
        logic [XLEN-1:0]   shifted;
        assign k       = index[i*BYTE_W +: BYTE_W];
        assign shifted = tbl >> {k, 3'b000};
        assign result[i*BYTE_W +: BYTE_W] =
            xbl_oob(k, LANES) ? '0 : shifted[BYTE_W-1:0];
    end

endmodule

// File: rtl/xbl_lookup.sv
module xbl_lookup
    import xbl_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_mode,
    input  logic [XLEN-1:0] in_tbl,
    input  logic [XLEN-1:0] in_index,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result
);
    localparam int unsigned NIB_LANES  = XLEN / NIB_W;
    localparam int unsigned BYTE_LANES = XLEN / BYTE_W;

    xbl_mode_e       mode;
    logic [XLEN-1:0] nib_res;
    logic [XLEN-1:0] byte_res;
    logic [XLEN-1:0] sel_res;

    assign mode = xbl_mode_e'(in_mode);

    xbl_nib_xbar #(.XLEN(XLEN)) u_nib (
        .tbl    (in_tbl),
        .index  (in_index),
        .result (nib_res)
    );

    xbl_byte_xbar #(.XLEN(XLEN)) u_byte (
        .tbl    (in_tbl),
        .index  (in_index),
        .result (byte_res)
    );

    always_comb begin
        unique case (mode)
            XBL_BYTE: sel_res = byte_res;
            default:  sel_res = nib_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= sel_res;
            end
        end
    end

    // R5: fixed one-cycle latency for every accepted operation
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6: idle cycle gives no valid and leaves the result unchanged
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));

    // R3: an out-of-range nibble index in lane 0 yields a zero nibble
    a_r3_nib_oob_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mode && xbl_oob({4'd0, in_index[3:0]}, NIB_LANES))
        |=> out_result[3:0] == 4'd0);

    // R4: an out-of-range byte index in lane 0 yields a zero byte
    a_r4_byte_oob_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode && xbl_oob(in_index[7:0], BYTE_LANES))
        |=> out_result[7:0] == 8'd0);

    // R7: reset clears the outputs on the next edge
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

endmodule

// File: tb/xbl_lookup_test.sv
`timescale 1ns/1ps
module xbl_lookup_test;
    localparam int unsigned XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_mode = 1'b0;
    logic [XLEN-1:0] in_tbl = '0;
    logic [XLEN-1:0] in_index = '0;
    logic            out_valid;
    logic [XLEN-1:0] out_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    xbl_lookup #(.XLEN(XLEN)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_tbl(in_tbl), .in_index(in_index),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Reference: element width w, n = XLEN/w entries, lane i takes entry k.
    function automatic logic [XLEN-1:0] ref_lookup(input logic mode,
            input logic [XLEN-1:0] t, input logic [XLEN-1:0] ix);
        int unsigned w, n, mask, k;
        logic [XLEN-1:0] r;
        w = mode ? 8 : 4;
        n = XLEN / w;
        mask = (1 << w) - 1;
        r = '0;
        for (int i = 0; i < int'(n); i++) begin
            k = int'((ix >> (i * w))) & mask;
            if (k < n)
                r = r | ((((t >> (k * w))) & XLEN'(mask)) << (i * w));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, check it one edge later.
    task automatic run_op(input string req, input logic mode,
                          input logic [XLEN-1:0] t, input logic [XLEN-1:0] ix);
        in_valid = 1'b1;
        in_mode  = mode;
        in_tbl   = t;
        in_index = ix;
        @(negedge clk);
        check({req, " valid"}, XLEN'(out_valid), XLEN'(1));
        check(req, out_result, ref_lookup(mode, t, ix));
    endtask

    initial begin
        logic [XLEN-1:0] held;
        logic [XLEN-1:0] ix;
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 valid", XLEN'(out_valid), '0);
        check("R7 result", out_result, '0);
        rst = 1'b0;

        // R1/R3: every nibble index value in every lane, rotated per lane
        for (int v = 0; v < 16; v++) begin
            for (int rep = 0; rep < 3; rep++) begin
                ix = '0;
                for (int i = 0; i < 8; i++) ix[i*4 +: 4] = 4'((v + i * rep) % 16);
                rng = next_rand(rng);
                run_op(v < 8 ? "R1 nibble" : "R3 nibble oob", 1'b0, rng, ix);
            end
        end
        // R3: every nibble index out of range gives zero
        run_op("R3 all oob", 1'b0, 32'hFFFF_FFFF, 32'hFEDC_BA98);
        check("R3 all oob zero", out_result, '0);

        // R2/R4: every byte index value in every lane
        for (int v = 0; v < 256; v++) begin
            ix = '0;
            for (int i = 0; i < 4; i++) ix[i*8 +: 8] = 8'((v + i * 37) % 256);
            rng = next_rand(rng);
            run_op(v < 4 ? "R2 byte" : "R4 byte oob", 1'b1, rng, ix);
            ix = {4{8'(v)}};
            run_op(v < 4 ? "R2 byte rep" : "R4 byte oob", 1'b1, ~rng, ix);
        end
        // R4: all byte indexes out of range
        run_op("R4 all oob", 1'b1, 32'hA5A5_A5A5, 32'h0405_FF80);
        check("R4 all oob zero", out_result, '0);

        // R1/R2: one element replicated to all positions
        run_op("R1 replicate", 1'b0, 32'h7654_3210, 32'h5555_5555);
        check("R1 replicate value", out_result, 32'h5555_5555);
        run_op("R2 replicate", 1'b1, 32'hDDCC_BBAA, 32'h0202_0202);
        check("R2 replicate value", out_result, 32'hCCCC_CCCC);
        run_op("R1 reverse", 1'b0, 32'h7654_3210, 32'h0123_4567);
        check("R1 reverse value", out_result, 32'h0123_4567);

        // R6: idle cycles ignore changing operands and hold the result
        held = out_result;
        for (int c = 0; c < 4; c++) begin
            in_valid = 1'b0;
            in_mode  = c[0];
            in_tbl   = next_rand(rng + c);
            in_index = '0;
            @(negedge clk);
            check("R6 idle valid", XLEN'(out_valid), '0);
            check("R6 idle hold", out_result, held);
        end

        // R5: back-to-back mixed modes after idle
        for (int c = 0; c < 20; c++) begin
            rng = next_rand(rng);
            run_op("R5 back-to-back", c[0], rng, next_rand(rng ^ 32'h33));
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R5 valid drop", XLEN'(out_valid), '0);

        // R7: reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        check("R7 mid reset valid", XLEN'(out_valid), '0);
        check("R7 mid reset result", out_result, '0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule